// File: doc/BRIEF.md
# Verified Scratchpad with Block Copy

This block is a 64-byte staging buffer that sits in front of password-protected key storage. A host talks to it over a byte stream. Each command starts with a three-byte header: an operation code, an address byte and the ones-complement of that address byte. The buffer itself needs no password. The host fills it, reads it back to confirm the contents, and then asks the block to move a chosen region into the secure storage of one subkey.

The copy command is followed by a one-byte region selector and by the eight password bytes of the destination subkey. The block presents the collected password and the subkey number to the storage, which answers with a match signal. When the selector is valid and the password matches, the block streams the selected bytes to the storage write port, one byte per clock. Each source byte is erased as it leaves. A one-cycle done pulse then reports that the transfer is complete. A transaction reset input ends any command, and the next received byte is again taken as an operation code.

Top module: `verified_stage_buffer`

## Requirements
- R1: After reset every buffer byte reads back as 00h, and no storage write or done pulse occurs.
- R2: Opcode 96h writes the received bytes into the buffer. Writing starts at address byte bits [5:0] and the address rises by one per byte.
- R3: Opcode 69h returns buffer bytes starting at address byte bits [5:0]. Each tx_req yields tx_valid with the byte one clock later, and the address rises by one per request.
- R4: Bytes written after address 63 has been passed are ignored. Reads past address 63 return FFh.
- R5: If the third header byte is not the bitwise inverse of the second, the command is dropped. No buffer byte changes, and reads return FFh until the next transaction reset.
- R6: Opcode 3Ch with selector value n in 0..7 writes buffer bytes 8n..8n+7 to storage in rising address order, one per clock. store_addr equals the buffer address, store_data equals the buffer byte, and store_key equals address byte bits [7:6].
- R7: Selector value 8 copies all 64 bytes, addresses 0 to 63 in order, through the same port.
- R8: A selector value above 8 aborts the copy. No storage write and no done pulse occur, and the buffer keeps its contents.
- R9: The eight password bytes after the selector form pw_cand, with the first byte in bits [7:0]. If pw_ok is low while pw_chk is high, no storage write and no done pulse occur, and the buffer keeps its contents.
- R10: After a successful copy the copied bytes read 00h and all other bytes keep their values.
- R11: copy_done is high for exactly one cycle, the cycle right after the last storage write.
- R12: A transaction reset ends the current command. An unknown opcode makes the block ignore input bytes until the next transaction reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xact_rst | input | 1 | Transaction reset; the next byte is an opcode |
| rx_valid | input | 1 | Host byte valid |
| rx_byte | input | 8 | Host byte |
| tx_req | input | 1 | Host requests one byte |
| tx_valid | output | 1 | Returned byte valid, one clock after tx_req |
| tx_byte | output | 8 | Returned byte |
| store_we | output | 1 | Storage write strobe |
| store_key | output | 2 | Destination subkey |
| store_addr | output | 6 | Destination byte address |
| store_data | output | 8 | Byte to store |
| pw_chk | output | 1 | Password compare requested this cycle |
| pw_key | output | 2 | Subkey whose password is compared |
| pw_cand | output | 64 | Collected password, first byte in [7:0] |
| pw_ok | input | 1 | Storage reports a password match |
| copy_done | output | 1 | One-cycle pulse after the copy finishes |

## Verification
On every cycle, the assertions check the following. No write follows a failed password or selector check. Storage writes during a copy carry consecutive addresses. Each done pulse comes right after a storage write. A read request past the end returns FFh. A transaction reset suppresses any following write. Only the bench scenarios can show the rest. These are that the streamed bytes equal the staged contents, that the erased region reads 00h while its neighbours survive, that malformed headers and unknown opcodes leave the buffer unchanged, and that each of the nine selector codes moves exactly its own region.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
   typedef enum logic [3:0] {
      ST_OPC, ST_ADR, ST_INV, ST_WR, ST_RD,
      ST_SEL, ST_PW, ST_CHK, ST_COPY, ST_HALT
   } vsb_state_e;

   localparam logic [7:0] OPC_WRITE = 8'h96;
   localparam logic [7:0] OPC_READ  = 8'h69;
   localparam logic [7:0] OPC_COPY  = 8'h3C;
   localparam logic [7:0] PAST_END  = 8'hFF;
endpackage

// File: rtl/vsb_store.sv
module vsb_store #(
   parameter int DEPTH = 64,
   parameter int DW = 8,
   parameter bit RESET_CELLS = 1'b1,
   parameter logic [DW-1:0] INIT_VAL = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DW-1:0]            rdata
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("vsb_store: DEPTH must be a power of two");
   end

   logic [DW-1:0] cellv [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] q;
      if (RESET_CELLS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      q <= INIT_VAL;
            else if (we && waddr == AW'(g))  q <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) q <= wdata;
         end
      end
      assign cellv[g] = q;
   end

   assign rdata = cellv[raddr];

   // R2
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == raddr) |=> (rdata == $past(wdata) || !$stable(raddr)));
endmodule

// File: rtl/vsb_blk_sel.sv
module vsb_blk_sel #(
   parameter int DEPTH = 64,
   parameter int BLK_BYTES = 8
) (
   input  logic [7:0]               sel,
   output logic                     sel_ok,
   output logic [$clog2(DEPTH)-1:0] base,
   output logic [$clog2(DEPTH)-1:0] last
);
   localparam int AW    = $clog2(DEPTH);
   localparam int BW    = $clog2(BLK_BYTES);
   localparam int NBLK  = DEPTH / BLK_BYTES;
   localparam int IDX_W = AW - BW;

   if (BLK_BYTES != (1 << BW) || BLK_BYTES < 2) begin : g_bad_blk
      $error("vsb_blk_sel: BLK_BYTES must be a power of two >= 2");
   end
   if (NBLK < 2 || NBLK > 254) begin : g_bad_nblk
      $error("vsb_blk_sel: block count out of range");
   end

   logic whole;
   assign whole  = (sel == 8'(NBLK));
   assign sel_ok = (sel <= 8'(NBLK));

   always_comb begin
      if (whole) begin
         base = '0;
         last = '1;
      end else begin
         base = {sel[IDX_W-1:0], {BW{1'b0}}};
         last = {sel[IDX_W-1:0], {BW{1'b1}}};
      end
   end
endmodule

// File: rtl/vsb_ctrl.sv
module vsb_ctrl
   import vsb_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int BLK_BYTES = 8,
   parameter int PW_BYTES = 8,
   parameter logic [7:0] ERASE_VAL = 8'h00
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           xact_rst,
   input  logic                           rx_valid,
   input  logic [7:0]                     rx_byte,
   input  logic                           tx_req,
   output logic                           tx_valid,
   output logic [7:0]                     tx_byte,
   output logic                           mem_we,
   output logic [$clog2(DEPTH)-1:0]       mem_waddr,
   output logic [7:0]                     mem_wdata,
   output logic [$clog2(DEPTH)-1:0]       mem_raddr,
   input  logic [7:0]                     mem_rdata,
   output logic                           store_we,
   output logic [7-$clog2(DEPTH):0]       store_key,
   output logic [$clog2(DEPTH)-1:0]       store_addr,
   output logic [7:0]                     store_data,
   output logic                           pw_chk,
   output logic [7-$clog2(DEPTH):0]       pw_key,
   output logic [PW_BYTES*8-1:0]          pw_cand,
   input  logic                           pw_ok,
   output logic                           copy_done
);
   localparam int AW   = $clog2(DEPTH);
   localparam int PC_W = $clog2(PW_BYTES);
   localparam logic [AW:0]   PTR_ONE = 1;
   localparam logic [AW-1:0] CUR_ONE = 1;
   localparam logic [PC_W-1:0] PC_ONE  = 1;
   localparam logic [PC_W-1:0] PC_LAST = PC_W'(PW_BYTES - 1);

   if (PW_BYTES < 2 || PW_BYTES != (1 << PC_W)) begin : g_bad_pw
      $error("vsb_ctrl: PW_BYTES must be a power of two >= 2");
   end

   vsb_state_e state_q, state_d;
   logic [7:0]            op_q, op_d;
   logic [7:0]            adr_q, adr_d;
   logic [AW:0]           ptr_q, ptr_d;
   logic [7:0]            sel_q, sel_d;
   logic [PW_BYTES*8-1:0] pw_q, pw_d;
   logic [PC_W-1:0]       pc_q, pc_d;
   logic [AW-1:0]         cur_q, cur_d;
   logic                  done_d;
   logic                  txv_d;
   logic [7:0]            txb_d;

   logic                  sel_ok;
   logic [AW-1:0]         sel_base, sel_last;

   vsb_blk_sel #(.DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES)) u_sel (
      .sel    (sel_q),
      .sel_ok (sel_ok),
      .base   (sel_base),
      .last   (sel_last)
   );

   always_comb begin
      state_d   = state_q;
      op_d      = op_q;
      adr_d     = adr_q;
      ptr_d     = ptr_q;
      sel_d     = sel_q;
      pw_d      = pw_q;
      pc_d      = pc_q;
      cur_d     = cur_q;
      done_d    = 1'b0;
      mem_we    = 1'b0;
      mem_waddr = ptr_q[AW-1:0];
      mem_wdata = rx_byte;
      mem_raddr = ptr_q[AW-1:0];
      store_we  = 1'b0;
      txv_d     = tx_req;
      txb_d     = PAST_END;
      unique case (state_q)
         ST_OPC: if (rx_valid) begin
            op_d = rx_byte;
            if (rx_byte == OPC_WRITE || rx_byte == OPC_READ || rx_byte == OPC_COPY)
               state_d = ST_ADR;
            else
               state_d = ST_HALT;
         end
         ST_ADR: if (rx_valid) begin
            adr_d   = rx_byte;
            state_d = ST_INV;
         end
         ST_INV: if (rx_valid) begin
            ptr_d = {1'b0, adr_q[AW-1:0]};
            if (rx_byte != ~adr_q)        state_d = ST_HALT;
            else if (op_q == OPC_WRITE)   state_d = ST_WR;
            else if (op_q == OPC_READ)    state_d = ST_RD;
            else                          state_d = ST_SEL;
         end
         ST_WR: if (rx_valid && !ptr_q[AW]) begin
            mem_we = 1'b1;
            ptr_d  = ptr_q + PTR_ONE;
         end
         ST_RD: begin
            if (!ptr_q[AW]) txb_d = mem_rdata;
            if (tx_req && !ptr_q[AW]) ptr_d = ptr_q + PTR_ONE;
         end
         ST_SEL: if (rx_valid) begin
            sel_d   = rx_byte;
            pc_d    = '0;
            state_d = ST_PW;
         end
         ST_PW: if (rx_valid) begin
            pw_d = {rx_byte, pw_q[PW_BYTES*8-1:8]};
            pc_d = pc_q + PC_ONE;
            if (pc_q == PC_LAST) state_d = ST_CHK;
         end
         ST_CHK: begin
            if (sel_ok && pw_ok) begin
               cur_d   = sel_base;
               state_d = ST_COPY;
            end else begin
               state_d = ST_HALT;
            end
         end
         ST_COPY: begin
            mem_raddr = cur_q;
            mem_waddr = cur_q;
            mem_wdata = ERASE_VAL;
            mem_we    = 1'b1;
            store_we  = 1'b1;
            if (cur_q == sel_last) begin
               done_d  = 1'b1;
               state_d = ST_HALT;
            end else begin
               cur_d = cur_q + CUR_ONE;
            end
         end
         ST_HALT: ;
         default: state_d = ST_HALT;
      endcase
      if (xact_rst) state_d = ST_OPC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OPC;
         op_q      <= '0;
         adr_q     <= '0;
         ptr_q     <= '0;
         sel_q     <= '0;
         pw_q      <= '0;
         pc_q      <= '0;
         cur_q     <= '0;
         copy_done <= 1'b0;
         tx_valid  <= 1'b0;
         tx_byte   <= PAST_END;
      end else begin
         state_q   <= state_d;
         op_q      <= op_d;
         adr_q     <= adr_d;
         ptr_q     <= ptr_d;
         sel_q     <= sel_d;
         pw_q      <= pw_d;
         pc_q      <= pc_d;
         cur_q     <= cur_d;
         copy_done <= done_d;
         tx_valid  <= txv_d;
         tx_byte   <= txb_d;
      end
   end

   assign store_key  = adr_q[7:AW];
   assign store_addr = cur_q;
   assign store_data = mem_rdata;
   assign pw_chk     = (state_q == ST_CHK);
   assign pw_key     = adr_q[7:AW];
   assign pw_cand    = pw_q;

   // R9
   pw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_chk && !pw_ok) |=> !store_we);
   // R8
   sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_chk && !sel_ok) |=> (!store_we && !copy_done));
   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (store_we && $past(store_we)) |-> (store_addr == $past(store_addr) + CUR_ONE));
   // R11
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |-> ($past(store_we) && !store_we));
   // R4
   read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && state_q == ST_RD && ptr_q[AW]) |=> (tx_valid && tx_byte == PAST_END));
   // R12
   xact_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xact_rst |=> !store_we);
endmodule

// File: rtl/verified_stage_buffer.sv
module verified_stage_buffer #(
   parameter int DEPTH = 64,
   parameter int BLK_BYTES = 8,
   parameter int PW_BYTES = 8,
   parameter logic [7:0] ERASE_VAL = 8'h00,
   parameter bit RESET_CELLS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     xact_rst,
   input  logic                     rx_valid,
   input  logic [7:0]               rx_byte,
   input  logic                     tx_req,
   output logic                     tx_valid,
   output logic [7:0]               tx_byte,
   output logic                     store_we,
   output logic [7-$clog2(DEPTH):0] store_key,
   output logic [$clog2(DEPTH)-1:0] store_addr,
   output logic [7:0]               store_data,
   output logic                     pw_chk,
   output logic [7-$clog2(DEPTH):0] pw_key,
   output logic [PW_BYTES*8-1:0]    pw_cand,
   input  logic                     pw_ok,
   output logic                     copy_done
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || DEPTH > 128) begin : g_bad_range
      $error("verified_stage_buffer: DEPTH must leave room for a subkey field");
   end
   if (DEPTH % BLK_BYTES != 0) begin : g_bad_split
      $error("verified_stage_buffer: DEPTH must be a multiple of BLK_BYTES");
   end

   logic          mem_we;
   logic [AW-1:0] mem_waddr, mem_raddr;
   logic [7:0]    mem_wdata, mem_rdata;

   vsb_ctrl #(
      .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES),
      .PW_BYTES(PW_BYTES), .ERASE_VAL(ERASE_VAL)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .xact_rst   (xact_rst),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .tx_req     (tx_req),
      .tx_valid   (tx_valid),
      .tx_byte    (tx_byte),
      .mem_we     (mem_we),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata),
      .mem_raddr  (mem_raddr),
      .mem_rdata  (mem_rdata),
      .store_we   (store_we),
      .store_key  (store_key),
      .store_addr (store_addr),
      .store_data (store_data),
      .pw_chk     (pw_chk),
      .pw_key     (pw_key),
      .pw_cand    (pw_cand),
      .pw_ok      (pw_ok),
      .copy_done  (copy_done)
   );

   vsb_store #(
      .DEPTH(DEPTH), .DW(8), .RESET_CELLS(RESET_CELLS), .INIT_VAL(ERASE_VAL)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );
endmodule

// File: tb/verified_stage_buffer_tb.sv
module verified_stage_buffer_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, xact_rst, rx_valid, tx_req, pw_ok;
   logic [7:0]  rx_byte;
   logic        tx_valid, store_we, pw_chk, copy_done;
   logic [7:0]  tx_byte, store_data;
   logic [1:0]  store_key, pw_key;
   logic [5:0]  store_addr;
   logic [63:0] pw_cand;

   verified_stage_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .xact_rst(xact_rst),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
      .tx_valid(tx_valid), .tx_byte(tx_byte),
      .store_we(store_we), .store_key(store_key), .store_addr(store_addr),
      .store_data(store_data), .pw_chk(pw_chk), .pw_key(pw_key),
      .pw_cand(pw_cand), .pw_ok(pw_ok), .copy_done(copy_done)
   );

   logic [63:0] pwtab [4];
   assign pw_ok = (pw_cand == pwtab[pw_key]);

   int n_chk = 0, n_bad = 0;
   logic [7:0] sb [64];

   int cyc = 0, wr_n = 0, last_wr = 0, done_n = 0, done_cyc = 0;
   int la [128];
   int ld [128];
   int lk [128];

   always @(negedge clk) begin
      cyc++;
      if (store_we) begin
         if (wr_n < 128) begin
            la[wr_n] = int'(store_addr);
            ld[wr_n] = int'(store_data);
            lk[wr_n] = int'(store_key);
         end
         wr_n++;
         last_wr = cyc;
      end
      if (copy_done) begin
         done_n++;
         done_cyc = cyc;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic bus_reset();
      xact_rst = 1'b1;
      @(negedge clk);
      xact_rst = 1'b0;
   endtask

   task automatic rd_byte(output logic [7:0] v, output logic vld);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
      v   = tx_byte;
      vld = tx_valid;
   endtask

   task automatic header(logic [7:0] opc, logic [7:0] a);
      send(opc);
      send(a);
      send(~a);
   endtask

   task automatic read_all(string tag);
      logic [7:0] v;
      logic vld;
      bus_reset();
      header(8'h69, 8'h00);
      for (int i = 0; i < 66; i++) begin
         rd_byte(v, vld);
         chk({tag, " data"}, int'(v), (i < 64) ? int'(sb[i]) : 8'hFF);
         if (i == 0 || i == 65) chk("R3 valid", int'(vld), 1);
      end
   endtask

   task automatic fill(int seed);
      logic [7:0] v;
      bus_reset();
      header(8'h96, 8'h00);
      for (int i = 0; i < 64; i++) begin
         v = 8'((seed * 37 + i * 11 + 5) & 255);
         send(v);
         sb[i] = v;
      end
   endtask

   task automatic do_copy(int key, int sel, logic [63:0] pw, bit exp_ok, string tag);
      logic [7:0] a;
      int base, len;
      bus_reset();
      wr_n = 0;
      done_n = 0;
      a = {2'(key), 6'd17};
      header(8'h3C, a);
      send(8'(sel));
      for (int k = 0; k < 8; k++) send(pw[8*k +: 8]);
      repeat (80) @(negedge clk);
      if (!exp_ok || sel > 8) begin
         chk({tag, " no writes"}, wr_n, 0);
         chk({tag, " no done"}, done_n, 0);
      end else begin
         base = (sel == 8) ? 0 : sel * 8;
         len  = (sel == 8) ? 64 : 8;
         chk({tag, " write count"}, wr_n, len);
         for (int i = 0; i < len; i++) begin
            chk({tag, " addr"}, la[i], base + i);
            chk({tag, " data"}, ld[i], int'(sb[base + i]));
            chk({tag, " key"}, lk[i], key);
         end
         chk("R11 done count", done_n, 1);
         chk("R11 done timing", done_cyc - last_wr, 1);
         for (int i = 0; i < len; i++) sb[base + i] = 8'h00;
      end
      read_all("R10 after copy");
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic vld;
      int starts [3] = '{0, 13, 60};
      int cnts [3] = '{64, 20, 10};
      rst_n = 1'b0; xact_rst = 1'b0; rx_valid = 1'b0; tx_req = 1'b0; rx_byte = '0;
      for (int k = 0; k < 4; k++) pwtab[k] = 64'h0123456789ABCDEF ^ (64'(k + 1) * 64'h1111_0000_2222_0003);
      for (int i = 0; i < 64; i++) sb[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 store_we", int'(store_we), 0);
      chk("R1 copy_done", int'(copy_done), 0);
      read_all("R1 reset");

      // R2 and R4: sweeps of start addresses, last one runs past the end
      for (int s = 0; s < 3; s++) begin
         bus_reset();
         header(8'h96, 8'(starts[s]));
         for (int i = 0; i < cnts[s]; i++) begin
            v = 8'((starts[s] * 5 + i * 3 + 1) & 255);
            send(v);
            if (starts[s] + i < 64) sb[starts[s] + i] = v;
         end
         read_all("R2 R4 write sweep");
      end

      // R3: read from a middle address past the end
      bus_reset();
      header(8'h69, 8'd40);
      for (int i = 0; i < 30; i++) begin
         rd_byte(v, vld);
         chk("R3 offset read", int'(v), (40 + i < 64) ? int'(sb[40 + i]) : 8'hFF);
      end

      // R5: bad complement on write and read
      bus_reset();
      send(8'h96); send(8'h05); send(8'h00);
      for (int i = 0; i < 4; i++) send(8'hA5);
      read_all("R5 bad write header");
      bus_reset();
      send(8'h69); send(8'h00); send(8'h01);
      rd_byte(v, vld);
      chk("R5 bad read header", int'(v), 8'hFF);

      // R12: reset mid-write, then unknown opcode
      bus_reset();
      header(8'h96, 8'h02);
      send(8'h5C); sb[2] = 8'h5C;
      bus_reset();
      send(8'h11);
      send(8'h96); send(8'h00); send(8'hFF);
      for (int i = 0; i < 4; i++) send(8'h77);
      read_all("R12 unknown opcode");

      // R6 and R7: every selector code with the right password
      for (int s = 0; s < 9; s++) begin
         fill(s);
         do_copy(s % 4, s, pwtab[s % 4], 1'b1, (s == 8) ? "R7 whole" : "R6 block");
      end
      fill(20);
      do_copy(3, 8, pwtab[3], 1'b1, "R7 whole key3");

      // R9: wrong password
      fill(30);
      do_copy(1, 3, pwtab[1] ^ 64'h1, 1'b0, "R9 flipped bit");
      do_copy(1, 8, pwtab[2], 1'b0, "R9 other key");
      do_copy(2, 0, {pwtab[2][7:0], pwtab[2][63:8]}, 1'b0, "R9 byte order");

      // R8: invalid selectors
      do_copy(0, 9, pwtab[0], 1'b1, "R8 sel 9");
      do_copy(0, 255, pwtab[0], 1'b1, "R8 sel FF");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule